// File: doc/BRIEF.md
# Codec Control-Word Initialization Sequencer

This block brings a chain of cascaded voice codecs out of their power-on control state and into conversion. Software loads a table of 16-bit control words and a sequence length, then pulses a start strobe. The block releases the codec reset line and raises the serial-enable line. Each of these lines passes through a flip-flop clocked by the codec master clock, so every device in the chain sees the edge at the same moment. From then on, every transmit slot that the serial port asks for takes the next table entry. A pointer walks the table as a circular buffer, and its wrap back to entry 0 marks the end of initialization.

After initialization the block feeds DAC sample words to the port. It can also place mixed-mode control updates ahead of the sample. How many control words fit into one sample period depends on the framing mode. In loop-back framing each codec takes at most one control word per period, and in run mode a control word takes the place of the sample, so that slot is flagged as a repeated-sample slot. In non-loop-back framing the whole table may go out within one period, and run-mode control words are accepted only until the period's sample word has been sent.

A slot request is answered one clock later with a registered word on `tx_word` and a kind code on `tx_kind`. Only the register-select field (bits 10:8, 000 = register A up to 111 = register H) and the control marker (bit 15 set) have meaning to the chain. The block does not interpret any other field.

Top module: `cis_seq`

## Requirements
- R1: While reset is held and until the first start pulse, `tx_valid`, `init_done`, `tx_repeat`, `ctrl_ack`, `codec_rst_n` and `codec_se` are 0. A slot requested before any start returns kind 0 (idle) with word 0x0000.
- R2: One start pulse drives `codec_rst_n` and `codec_se` high. Both lines change only at rising edges of `mclk` and never at any other instant.
- R3: Every `slot_req` cycle produces `tx_valid` = 1 for exactly one cycle, on the next clock. During initialization the word sent is the table entry at the pointer, with kind code 1 (control). The entries go out in order starting at entry 0.
- R4: The slot that sends entry `seq_len`-1 wraps the pointer to 0. `init_done` rises together with that word's `tx_valid`. A `seq_len` of 0 behaves as 1.
- R5: In loop-back framing (`loopback` = 1), at most `codec_cnt` control words go out per sample period. A period begins at a slot with `slot_first` = 1. Surplus slots return kind 0 with word 0x0000, and the pointer does not advance.
- R6: In non-loop-back framing, every slot of a period may carry a table entry, so a whole sequence completes within a single period.
- R7: After initialization, a slot with no pending control update returns `dac_word` with kind code 2 (sample).
- R8: In non-loop-back run mode, a pending `ctrl_word` is sent with kind 1 and `ctrl_ack` = 1 only before the period's sample. Once the sample has gone out, later slots in that period return kind 0, and a pending update stays unacknowledged.
- R9: In loop-back run mode, a pending update within the per-period quota replaces the sample. It is sent with kind 1, `tx_repeat` = 1 and `ctrl_ack` = 1.
- R10: A start pulse while initialization is in progress is ignored, and the sequence continues from the current pointer. A start after `init_done` clears `init_done` and restarts from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk | input | 1 | Codec master clock for the line flip-flops |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 5 | Table write address |
| tbl_wdata | input | 16 | Table write data |
| seq_len | input | 6 | Number of table entries in the sequence |
| codec_cnt | input | 4 | Codecs in the chain (loop-back quota per period) |
| loopback | input | 1 | 1 = loop-back framing, 0 = non-loop-back |
| start | input | 1 | Start strobe |
| slot_req | input | 1 | Port requests a word for the next slot |
| slot_first | input | 1 | This slot opens a new sample period |
| ctrl_req | input | 1 | A mixed-mode control update is pending |
| ctrl_word | input | 16 | The pending control update |
| dac_word | input | 16 | DAC sample for this period |
| tx_valid | output | 1 | Word on tx_word answers a slot |
| tx_word | output | 16 | Transmit word |
| tx_kind | output | 2 | 0 idle, 1 control, 2 sample |
| tx_repeat | output | 1 | Control word displaced the sample (repeated sample) |
| ctrl_ack | output | 1 | Pending update was consumed |
| init_done | output | 1 | Table sequence completed |
| codec_rst_n | output | 1 | Codec reset line, registered on mclk |
| codec_se | output | 1 | Codec serial-enable line, registered on mclk |

## Verification
The bench goes after the wrap: a design off by one on the last entry would either drop the final register-A write or resend entry 0 before raising `init_done`. It runs loop-back periods with more slots than codecs, so that a missing quota would leak table entries into idle slots or skip the pointer. In non-loop-back run mode it keeps an update pending after the sample has gone out. A design that ignored the ordering would send a control word after the sample, and one that acknowledged it anyway would lose the update. It also times each change of the codec lines against the last `mclk` edge, which catches lines driven straight from the sequencer clock. A mid-sequence start pulse checks that the pointer is not rewound.

// File: rtl/cis_pkg.sv
`timescale 1ns/1ps
package cis_pkg;
   typedef enum logic [1:0] {
      K_IDLE   = 2'd0,
      K_CTRL   = 2'd1,
      K_SAMPLE = 2'd2
   } kind_e;

   typedef enum logic [1:0] {
      S_OFF  = 2'd0,
      S_INIT = 2'd1,
      S_RUN  = 2'd2
   } state_e;
endpackage

// File: rtl/cis_table.sv
`timescale 1ns/1ps
module cis_table #(
   parameter int DEPTH  = 32,
   parameter int WORD_W = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/cis_quota.sv
`timescale 1ns/1ps
module cis_quota #(
   parameter int MAX_CODECS = 8,
   localparam int CW        = $clog2(MAX_CODECS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slot,
   input  logic          first,
   input  logic          loopback,
   input  logic [CW-1:0] codec_cnt,
   input  logic          inc_ctrl,
   input  logic          set_sent,
   output logic          ctrl_ok,
   output logic          cur_sent
);
   logic [CW-1:0] cnt_q;
   logic          sent_q;
   logic [CW-1:0] cur_cnt;

   assign cur_cnt  = first ? '0 : cnt_q;
   assign cur_sent = first ? 1'b0 : sent_q;
   assign ctrl_ok  = !loopback || (cur_cnt < codec_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sent_q <= 1'b0;
      end else if (slot) begin
         cnt_q  <= (inc_ctrl && cur_cnt != '1) ? cur_cnt + 1'b1 : cur_cnt;
         sent_q <= cur_sent | set_sent;
      end
   end
endmodule

// File: rtl/cis_line_sync.sv
`timescale 1ns/1ps
module cis_line_sync #(
   parameter int LINES = 2
) (
   input  logic             mclk,
   input  logic             rst_n,
   input  logic [LINES-1:0] d,
   output logic [LINES-1:0] q
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge mclk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= d[i];
      end
   end
endmodule

// File: rtl/cis_seq.sv
`timescale 1ns/1ps
module cis_seq
   import cis_pkg::*;
#(
   parameter int DEPTH      = 32,
   parameter int WORD_W     = 16,
   parameter int MAX_CODECS = 8,
   localparam int AW        = $clog2(DEPTH),
   localparam int LW        = $clog2(DEPTH + 1),
   localparam int CW        = $clog2(MAX_CODECS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mclk,
   input  logic              tbl_we,
   input  logic [AW-1:0]     tbl_addr,
   input  logic [WORD_W-1:0] tbl_wdata,
   input  logic [LW-1:0]     seq_len,
   input  logic [CW-1:0]     codec_cnt,
   input  logic              loopback,
   input  logic              start,
   input  logic              slot_req,
   input  logic              slot_first,
   input  logic              ctrl_req,
   input  logic [WORD_W-1:0] ctrl_word,
   input  logic [WORD_W-1:0] dac_word,
   output logic              tx_valid,
   output logic [WORD_W-1:0] tx_word,
   output logic [1:0]        tx_kind,
   output logic              tx_repeat,
   output logic              ctrl_ack,
   output logic              init_done,
   output logic              codec_rst_n,
   output logic              codec_se
);
   if (DEPTH < 32 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cis_seq: DEPTH must be a power of two of at least 32");
   end
   if (WORD_W < 16) begin : g_bad_width
      $error("cis_seq: WORD_W must be at least 16");
   end

   state_e            state_q;
   logic [AW-1:0]     ptr_q;
   logic [WORD_W-1:0] rd_word;
   logic              ctrl_ok, cur_sent;
   logic              adv, inc_ctrl, set_sent, sel_rep, sel_ack;
   kind_e             sel_kind;
   logic [WORD_W-1:0] sel_word;
   logic              last_entry;
   logic [1:0]        line_d;

   cis_table #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_table (
      .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
      .raddr(ptr_q), .rdata(rd_word)
   );

   cis_quota #(.MAX_CODECS(MAX_CODECS)) u_quota (
      .clk(clk), .rst_n(rst_n), .slot(slot_req), .first(slot_first),
      .loopback(loopback), .codec_cnt(codec_cnt), .inc_ctrl(inc_ctrl),
      .set_sent(set_sent), .ctrl_ok(ctrl_ok), .cur_sent(cur_sent)
   );

   assign last_entry = ({1'b0, ptr_q} + 1'b1) >= {1'b0, seq_len};

   always_comb begin
      sel_kind = K_IDLE;
      sel_word = '0;
      sel_rep  = 1'b0;
      sel_ack  = 1'b0;
      adv      = 1'b0;
      inc_ctrl = 1'b0;
      set_sent = 1'b0;
      unique case (state_q)
         S_INIT: begin
            if (ctrl_ok) begin
               sel_kind = K_CTRL;
               sel_word = rd_word;
               adv      = 1'b1;
               inc_ctrl = loopback;
            end
         end
         S_RUN: begin
            if (loopback) begin
               if (ctrl_req && ctrl_ok) begin
                  sel_kind = K_CTRL;
                  sel_word = ctrl_word;
                  sel_rep  = 1'b1;
                  sel_ack  = 1'b1;
                  inc_ctrl = 1'b1;
               end else begin
                  sel_kind = K_SAMPLE;
                  sel_word = dac_word;
               end
            end else if (!cur_sent) begin
               if (ctrl_req) begin
                  sel_kind = K_CTRL;
                  sel_word = ctrl_word;
                  sel_ack  = 1'b1;
               end else begin
                  sel_kind = K_SAMPLE;
                  sel_word = dac_word;
                  set_sent = 1'b1;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_OFF;
         ptr_q     <= '0;
         init_done <= 1'b0;
      end else if (start && state_q != S_INIT) begin
         state_q   <= S_INIT;
         ptr_q     <= '0;
         init_done <= 1'b0;
      end else if (slot_req && adv) begin
         if (last_entry) begin
            ptr_q     <= '0;
            state_q   <= S_RUN;
            init_done <= 1'b1;
         end else begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid  <= 1'b0;
         tx_word   <= '0;
         tx_kind   <= K_IDLE;
         tx_repeat <= 1'b0;
         ctrl_ack  <= 1'b0;
      end else begin
         tx_valid  <= slot_req;
         tx_word   <= slot_req ? sel_word : '0;
         tx_kind   <= slot_req ? sel_kind : K_IDLE;
         tx_repeat <= slot_req & sel_rep;
         ctrl_ack  <= slot_req & sel_ack;
      end
   end

   // line 0: reset release, line 1: serial enable
   assign line_d = {state_q != S_OFF, state_q != S_OFF};

   cis_line_sync #(.LINES(2)) u_lines (
      .mclk(mclk), .rst_n(rst_n), .d(line_d), .q({codec_se, codec_rst_n})
   );
endmodule

// File: rtl/cis_seq_chk.sv
`timescale 1ns/1ps
module cis_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mclk,
   input logic       loopback,
   input logic       slot_req,
   input logic       tx_valid,
   input logic [1:0] tx_kind,
   input logic       tx_repeat,
   input logic       ctrl_ack,
   input logic       init_done,
   input logic       codec_rst_n,
   input logic       codec_se
);
   // R3
   answer_follows_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(slot_req));
   // R4
   done_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (tx_valid && tx_kind == 2'd1));
   // R7
   sample_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_kind == 2'd2) |-> init_done);
   // R8
   ack_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_ack |-> (tx_valid && tx_kind == 2'd1 && init_done));
   // R9
   repeat_in_loopback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_repeat |-> (ctrl_ack && $past(loopback)));
   // R1
   quiet_without_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |-> (tx_kind == 2'd0 && !tx_repeat && !ctrl_ack));
   // R2
   se_with_reset_release_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      codec_se |-> codec_rst_n);
endmodule

bind cis_seq cis_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mclk(mclk), .loopback(loopback),
   .slot_req(slot_req), .tx_valid(tx_valid), .tx_kind(tx_kind),
   .tx_repeat(tx_repeat), .ctrl_ack(ctrl_ack), .init_done(init_done),
   .codec_rst_n(codec_rst_n), .codec_se(codec_se)
);

// File: tb/cis_seq_bench.sv
`timescale 1ns/1ps
module cis_seq_bench;
   logic        clk = 1'b0, mclk = 1'b0, rst_n = 1'b0;
   logic        tbl_we = 1'b0;
   logic [4:0]  tbl_addr = '0;
   logic [15:0] tbl_wdata = '0;
   logic [5:0]  seq_len = '0;
   logic [3:0]  codec_cnt = 4'd1;
   logic        loopback = 1'b0, start = 1'b0;
   logic        slot_req = 1'b0, slot_first = 1'b0, ctrl_req = 1'b0;
   logic [15:0] ctrl_word = '0, dac_word = '0;
   logic        tx_valid, tx_repeat, ctrl_ack, init_done, codec_rst_n, codec_se;
   logic [15:0] tx_word;
   logic [1:0]  tx_kind;

   int checks = 0, errors = 0;
   logic [15:0] ref_tbl [32];
   int  m_st = 0, m_ptr = 0, m_len = 1, m_codecs = 1, m_cnt = 0;
   bit  m_sent = 0, m_done = 0, m_lb = 0;
   time last_mclk = 0;
   bit  line_watch = 0;

   always #5 clk = ~clk;
   always #17 mclk = ~mclk;

   cis_seq u_cis_seq (.*);

   always @(posedge mclk) last_mclk = $time;
   // R2: codec lines move only on mclk rising edges
   always @(codec_rst_n or codec_se) begin
      if (line_watch) begin
         checks++;
         if ($time != last_mclk) begin
            errors++;
            $display("FAIL R2 line change at %0t, last mclk edge %0t", $time, last_mclk);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic load_table(input int len);
      for (int i = 0; i < 32; i++) begin
         logic [15:0] w;
         w = 16'h8000 | (16'(($urandom % 8)) << 8) | 16'($urandom % 256);
         if (i == len - 1) w[10:8] = 3'd0;
         ref_tbl[i] = w;
         @(negedge clk);
         tbl_we = 1'b1; tbl_addr = 5'(i); tbl_wdata = w;
      end
      @(negedge clk);
      tbl_we = 1'b0;
      seq_len = 6'(len);
      m_len = (len == 0) ? 1 : len;
   endtask

   task automatic set_mode(input bit lb, input int nc);
      @(negedge clk);
      loopback = lb; codec_cnt = 4'(nc);
      m_lb = lb; m_codecs = nc;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (m_st != 1) begin
         m_st = 1; m_ptr = 0; m_done = 0;
      end
   endtask

   task automatic slot(input bit first, input bit req, input logic [15:0] cw,
                       input logic [15:0] dw, output string tag);
      logic [1:0] ek; logic [15:0] ew; bit er, ea; int c; bit s;
      c = first ? 0 : m_cnt; s = first ? 1'b0 : m_sent;
      ek = 2'd0; ew = 16'h0; er = 0; ea = 0; tag = "R1";
      if (m_st == 1) begin
         if (!m_lb || c < m_codecs) begin
            ek = 2'd1; ew = ref_tbl[m_ptr]; tag = m_lb ? "R3" : "R6";
            if (m_lb) c++;
            if (m_ptr + 1 >= m_len) begin
               m_ptr = 0; m_st = 2; m_done = 1; tag = "R4";
            end else m_ptr++;
         end else tag = "R5";
      end else if (m_st == 2) begin
         tag = "R7";
         if (m_lb) begin
            if (req && c < m_codecs) begin
               ek = 2'd1; ew = cw; er = 1; ea = 1; c++; tag = "R9";
            end else begin
               ek = 2'd2; ew = dw;
            end
         end else if (!s) begin
            if (req) begin
               ek = 2'd1; ew = cw; ea = 1; tag = "R8";
            end else begin
               ek = 2'd2; ew = dw; s = 1;
            end
         end else tag = "R8";
      end
      m_cnt = c; m_sent = s;
      slot_req = 1'b1; slot_first = first; ctrl_req = req;
      ctrl_word = cw; dac_word = dw;
      @(negedge clk);
      slot_req = 1'b0; slot_first = 1'b0; ctrl_req = 1'b0;
      chk(tag, {tx_valid, tx_kind, tx_repeat, ctrl_ack, init_done, tx_word},
               {1'b1, ek, er, ea, m_done, ew});
   endtask

   initial begin
      string t;
      void'($urandom(32'd1234));
      #1000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      string t;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", {tx_valid, init_done, tx_repeat, ctrl_ack, codec_rst_n, codec_se}, 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {tx_valid, init_done, codec_rst_n, codec_se}, 4'b0);
      slot(1, 0, 16'h0, 16'h1111, t);
      // R6 / R4: whole sequence in one period, non-loop-back
      load_table(10);
      set_mode(0, 2);
      line_watch = 1;
      pulse_start();
      repeat (8) @(negedge clk);
      chk("R2", {codec_rst_n, codec_se}, 2'b11);
      for (int i = 0; i < 10; i++) slot(i == 0, 0, 16'h0, 16'h2222, t);
      chk("R4", init_done, 1'b1);
      // R8: ordering in non-loop-back run mode
      slot(1, 1, 16'h8A55, 16'h3333, t);
      slot(0, 0, 16'h0, 16'h3334, t);
      slot(0, 1, 16'h8B66, 16'h3335, t);
      slot(0, 1, 16'h8B67, 16'h3336, t);
      slot(1, 1, 16'h8B67, 16'h3337, t);
      // R5 / R10: loop-back init with quota and an ignored start
      load_table(6);
      set_mode(1, 2);
      pulse_start();
      chk("R10", init_done, 1'b0);
      slot(1, 0, 0, 0, t); slot(0, 0, 0, 0, t); slot(0, 0, 0, 0, t);
      pulse_start();
      slot(1, 0, 0, 0, t); slot(0, 0, 0, 0, t); slot(0, 0, 0, 0, t);
      slot(1, 0, 0, 0, t); slot(0, 0, 0, 0, t); slot(0, 0, 0, 0, t);
      // R9: control replaces sample in loop-back run mode
      slot(1, 1, 16'h8C01, 16'h4444, t);
      slot(0, 1, 16'h8C02, 16'h4445, t);
      slot(0, 1, 16'h8C03, 16'h4446, t);
      // R4: zero length acts as one
      load_table(0);
      set_mode(0, 1);
      pulse_start();
      slot(1, 0, 0, 16'h5555, t);
      slot(1, 0, 0, 16'h5556, t);
      // random phase
      for (int n = 0; n < 400; n++) begin
         if ($urandom % 60 == 0) begin
            load_table(1 + $urandom % 32);
            pulse_start();
         end
         if ($urandom % 25 == 0) set_mode($urandom % 2, 1 + $urandom % 8);
         slot($urandom % 4 == 0, $urandom % 2, 16'h8000 | 16'($urandom % 32768),
              16'($urandom), t);
      end
      line_watch = 0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule